// File: doc/BRIEF.md
# Banked Internal Data RAM Controller

This block is the 128-byte internal working memory of an 8-bit microcontroller core. One storage array sits behind four access paths: a register path that addresses eight registers inside the currently selected bank, a direct byte path that covers the whole 00h–7Fh range, a single-bit path into a 16-byte window, and a stack path. The stack path is driven by an 8-bit stack pointer that the block keeps itself.

The core selects the active bank through a small bank register inside the block. It issues at most one write per cycle on whichever path it needs. All four read paths are combinational from the array, so a read sees the address presented in the same cycle. A push moves the pointer up and then stores the byte. A pop returns the byte under the pointer and then moves the pointer down. When several requests collide in one cycle, a fixed priority decides which write lands, and every other write is dropped.

Top module: `idram_ctrl`

## Requirements
- R1: Reset sets the stack pointer to 07h and the bank register to 0. Memory contents are not cleared by reset.
- R2: A register access addresses byte `bank*8 + index`, where `bank` is the 2-bit value loaded by `bank_we` from `bank_sel` (0 gives 00h–07h, 3 gives 18h–1Fh). `reg_rdata` shows that byte, and `reg_we` writes it.
- R3: The byte path reads any address 00h–7Fh combinationally and writes `byte_wdata` there on `byte_we`.
- R4: Bit address b (0–127) selects byte 20h + (b >> 3), bit position b & 7 (bit 0 is the least significant). `bit_rdata` shows that bit.
- R5: A bit write changes only the selected bit and leaves the other seven bits of that byte unchanged.
- R6: A push increments the stack pointer by one and writes `stk_wdata` at the new pointer value.
- R7: `stk_rdata` shows the byte at the current stack pointer. A pop decrements the pointer by one after that cycle and writes nothing.
- R8: Stack pointer arithmetic wraps modulo 256 (00h pops to FFh, FFh pushes to 00h).
- R9: When the stack address is 80h or above, `stk_rdata` is 00h and a push writes no byte, although the pointer still moves.
- R10: Write priority is: stack operation (push or pop), then byte write, then register write, then bit write. A losing write in the same cycle has no effect.
- R11: When push and pop are asserted together, the push is performed and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_we | input | 1 | Load the bank register from `bank_sel` |
| bank_sel | input | 2 | New bank number |
| reg_idx | input | 3 | Register index within the active bank |
| reg_we | input | 1 | Register write request |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| byte_addr | input | 7 | Direct byte address |
| byte_we | input | 1 | Byte write request |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data |
| bit_addr | input | 7 | Bit address in the bit window |
| bit_we | input | 1 | Bit write request |
| bit_wdata | input | 1 | Bit write value |
| bit_rdata | output | 1 | Selected bit value |
| push | input | 1 | Stack push request |
| pop | input | 1 | Stack pop request |
| stk_wdata | input | 8 | Data to push |
| stk_rdata | output | 8 | Byte under the stack pointer |
| sp | output | 8 | Current stack pointer |

## Verification
The assertions assume that every request input has a defined value on each rising edge after reset is released. They also assume that the bit path's read byte depends only on `bit_addr` within the same cycle, so a read-modify-write always works on the byte the array holds before the edge. The bench changes all inputs on the falling edge and returns every request to zero one cycle later, so each request lasts exactly one cycle. Collisions between paths happen only in the directed priority cases, where the expected winner is known.

// File: rtl/idram_pkg.sv
package idram_pkg;
  localparam int DW      = 8;
  localparam int AW      = 7;
  localparam int SPW     = 8;
  localparam int IDXW    = 3;
  localparam int BANKW   = 2;
  localparam int BAW     = 7;
  localparam int NRD     = 4;
  localparam logic [7:0] BIT_BASE = 8'h20;
  localparam logic [7:0] SP_RST   = 8'h07;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_STACK = 3'd1,
    SRC_BYTE  = 3'd2,
    SRC_REG   = 3'd3,
    SRC_BIT   = 3'd4
  } wr_src_e;

  localparam int RD_REG  = 0;
  localparam int RD_BYTE = 1;
  localparam int RD_BIT  = 2;
  localparam int RD_STK  = 3;
endpackage

// File: rtl/idram_array.sv
module idram_array
  import idram_pkg::*;
#(
  parameter int W   = DW,
  parameter int A   = AW,
  parameter int NR  = NRD
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [A-1:0]          waddr,
  input  logic [W-1:0]          wdata,
  input  logic [NR-1:0][A-1:0]  raddr,
  output logic [NR-1:0][W-1:0]  rdata
);
  localparam int DEPTH = 1 << A;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NR; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata)); // R3
endmodule

// File: rtl/idram_stack.sv
module idram_stack
  import idram_pkg::*;
#(
  parameter int          W     = SPW,
  parameter logic [W-1:0] RST  = SP_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  output logic [W-1:0] sp_q,
  output logic [W-1:0] push_addr
);
  logic [W-1:0] sp_d;
  logic         sp_en;

  assign push_addr = sp_q + 1'b1;

  always_comb begin
    sp_en = push | pop;
    sp_d  = sp_q;
    if (push) begin
      sp_d = push_addr;
    end else if (pop) begin
      sp_d = sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= RST;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  AST_SP_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_q == ($past(sp_q) + 1'b1)); // R6

  AST_SP_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp_q == ($past(sp_q) - 1'b1)); // R7

  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(sp_q)); // R6
endmodule

// File: rtl/idram_wrarb.sv
module idram_wrarb
  import idram_pkg::*;
#(
  parameter int W  = DW,
  parameter int A  = AW,
  parameter int SW = SPW,
  parameter int BA = BAW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [SW-1:0] push_addr,
  input  logic [W-1:0]  stk_wdata,
  input  logic          byte_we,
  input  logic [A-1:0]  byte_addr,
  input  logic [W-1:0]  byte_wdata,
  input  logic          reg_we,
  input  logic [A-1:0]  reg_addr,
  input  logic [W-1:0]  reg_wdata,
  input  logic          bit_we,
  input  logic [BA-1:0] bit_addr,
  input  logic          bit_wdata,
  output logic [A-1:0]  bit_raddr,
  input  logic [W-1:0]  bit_old,
  output logic          we,
  output logic [A-1:0]  waddr,
  output logic [W-1:0]  wdata,
  output wr_src_e       src
);
  localparam int BIT_IDX = $clog2(W);
  localparam int BIT_ROW = BA - BIT_IDX;

  logic [W-1:0] bit_mask;
  logic         stk_in_range;
  logic [W-1:0] bit_merged;

  assign bit_raddr    = BIT_BASE[A-1:0] + A'(bit_addr[BA-1:BIT_IDX]);
  assign bit_mask     = W'(1) << bit_addr[BIT_IDX-1:0];
  assign stk_in_range = (push_addr[SW-1:A] == '0);
  assign bit_merged   = bit_wdata ? (bit_old | bit_mask) : (bit_old & ~bit_mask);

  always_comb begin
    we    = 1'b0;
    waddr = '0;
    wdata = '0;
    src   = SRC_NONE;
    if (push || pop) begin
      src = SRC_STACK;
      if (push && stk_in_range) begin
        we    = 1'b1;
        waddr = push_addr[A-1:0];
        wdata = stk_wdata;
      end
    end else if (byte_we) begin
      src   = SRC_BYTE;
      we    = 1'b1;
      waddr = byte_addr;
      wdata = byte_wdata;
    end else if (reg_we) begin
      src   = SRC_REG;
      we    = 1'b1;
      waddr = reg_addr;
      wdata = reg_wdata;
    end else if (bit_we) begin
      src   = SRC_BIT;
      we    = 1'b1;
      waddr = bit_raddr;
      wdata = bit_merged;
    end
  end

  AST_BIT_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_BIT) |-> ((wdata ^ bit_old) & ~bit_mask) == '0); // R5

  AST_HIGH_STACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_addr[SW-1]) |-> !we); // R9

  AST_STACK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |-> !we); // R10
endmodule

// File: rtl/idram_ctrl.sv
module idram_ctrl
  import idram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_we,
  input  logic [BANKW-1:0] bank_sel,
  input  logic [IDXW-1:0]  reg_idx,
  input  logic             reg_we,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [AW-1:0]    byte_addr,
  input  logic             byte_we,
  input  logic [DW-1:0]    byte_wdata,
  output logic [DW-1:0]    byte_rdata,
  input  logic [BAW-1:0]   bit_addr,
  input  logic             bit_we,
  input  logic             bit_wdata,
  output logic             bit_rdata,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    stk_wdata,
  output logic [DW-1:0]    stk_rdata,
  output logic [SPW-1:0]   sp
);
  localparam int RA_PAD  = AW - BANKW - IDXW;
  localparam int BIT_IDX = $clog2(DW);

  logic [1:0]            rst_sync_q;
  logic                  rst_core_n;
  logic [BANKW-1:0]      bank_q;
  logic [AW-1:0]         reg_addr;
  logic [SPW-1:0]        push_addr;
  logic [AW-1:0]         bit_raddr;
  logic                  arr_we;
  logic [AW-1:0]         arr_waddr;
  logic [DW-1:0]         arr_wdata;
  wr_src_e               arr_src;
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][DW-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      bank_q <= '0;
    end else if (bank_we) begin
      bank_q <= bank_sel;
    end
  end

  assign reg_addr = {{RA_PAD{1'b0}}, bank_q, reg_idx};

  idram_stack u_stack (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push      (push),
    .pop       (pop),
    .sp_q      (sp),
    .push_addr (push_addr)
  );

  idram_wrarb u_arb (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .push       (push),
    .pop        (pop),
    .push_addr  (push_addr),
    .stk_wdata  (stk_wdata),
    .byte_we    (byte_we),
    .byte_addr  (byte_addr),
    .byte_wdata (byte_wdata),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .bit_we     (bit_we),
    .bit_addr   (bit_addr),
    .bit_wdata  (bit_wdata),
    .bit_raddr  (bit_raddr),
    .bit_old    (rd_data[RD_BIT]),
    .we         (arr_we),
    .waddr      (arr_waddr),
    .wdata      (arr_wdata),
    .src        (arr_src)
  );

  assign rd_addr[RD_REG]  = reg_addr;
  assign rd_addr[RD_BYTE] = byte_addr;
  assign rd_addr[RD_BIT]  = bit_raddr;
  assign rd_addr[RD_STK]  = sp[AW-1:0];

  idram_array u_array (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign reg_rdata  = rd_data[RD_REG];
  assign byte_rdata = rd_data[RD_BYTE];
  assign bit_rdata  = rd_data[RD_BIT][bit_addr[BIT_IDX-1:0]];
  assign stk_rdata  = (sp[SPW-1:AW] == '0) ? rd_data[RD_STK] : '0;

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bank_we |=> $stable(bank_q)); // R2

  AST_SRC_STACK: assert property (@(posedge clk) disable iff (!rst_core_n)
    (push || pop) |-> (arr_src == SRC_STACK)); // R10
endmodule

// File: tb/idram_ctrl_test.sv
module idram_ctrl_test;
  logic       clk;
  logic       rst_n;
  logic       bank_we;
  logic [1:0] bank_sel;
  logic [2:0] reg_idx;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [6:0] byte_addr;
  logic       byte_we;
  logic [7:0] byte_wdata;
  logic [7:0] byte_rdata;
  logic [6:0] bit_addr;
  logic       bit_we;
  logic       bit_wdata;
  logic       bit_rdata;
  logic       push;
  logic       pop;
  logic [7:0] stk_wdata;
  logic [7:0] stk_rdata;
  logic [7:0] sp;

  int total = 0;
  int bad   = 0;

  idram_ctrl uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // op codes: 0 byte write, 1 byte read, 2 bit write, 3 bit read,
  // 4 register write (a = bank*8+idx), 5 register read
  localparam int NV = 33;
  localparam logic [26:0] VEC [NV] = '{
    {3'd0, 8'h30, 8'h5A, 8'h00}, {3'd1, 8'h30, 8'h00, 8'h5A},
    {3'd0, 8'h7F, 8'hC3, 8'h00}, {3'd1, 8'h7F, 8'h00, 8'hC3},
    {3'd4, 8'h03, 8'h11, 8'h00}, {3'd1, 8'h03, 8'h00, 8'h11},
    {3'd4, 8'h15, 8'h22, 8'h00}, {3'd1, 8'h15, 8'h00, 8'h22},
    {3'd4, 8'h1F, 8'h33, 8'h00}, {3'd1, 8'h1F, 8'h00, 8'h33},
    {3'd0, 8'h0A, 8'h44, 8'h00}, {3'd5, 8'h0A, 8'h00, 8'h44},
    {3'd5, 8'h03, 8'h00, 8'h11},
    {3'd0, 8'h25, 8'h00, 8'h00}, {3'd2, 8'h2B, 8'h01, 8'h00},
    {3'd1, 8'h25, 8'h00, 8'h08}, {3'd2, 8'h2F, 8'h01, 8'h00},
    {3'd1, 8'h25, 8'h00, 8'h88}, {3'd3, 8'h2B, 8'h00, 8'h01},
    {3'd3, 8'h2C, 8'h00, 8'h00},
    {3'd0, 8'h20, 8'hFF, 8'h00}, {3'd2, 8'h00, 8'h00, 8'h00},
    {3'd1, 8'h20, 8'h00, 8'hFE}, {3'd3, 8'h00, 8'h00, 8'h00},
    {3'd3, 8'h01, 8'h00, 8'h01},
    {3'd0, 8'h2F, 8'h00, 8'h00}, {3'd2, 8'h7F, 8'h01, 8'h00},
    {3'd1, 8'h2F, 8'h00, 8'h80}, {3'd2, 8'h7F, 8'h00, 8'h00},
    {3'd1, 8'h2F, 8'h00, 8'h00},
    {3'd0, 8'h2E, 8'hA5, 8'h00}, {3'd2, 8'h72, 8'h00, 8'h00},
    {3'd1, 8'h2E, 8'h00, 8'hA1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    bank_we = 1'b0; reg_we = 1'b0; byte_we = 1'b0;
    bit_we = 1'b0; push = 1'b0; pop = 1'b0;
  endtask

  task automatic set_bank(input logic [1:0] b);
    bank_sel = b; bank_we = 1'b1; tick();
  endtask

  task automatic wr_byte(input logic [6:0] a, input logic [7:0] d);
    byte_addr = a; byte_wdata = d; byte_we = 1'b1; tick();
  endtask

  task automatic rd_byte(input string tag, input logic [6:0] a, input logic [7:0] e);
    byte_addr = a; #1; chk(tag, byte_rdata, e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bank_we = 0; bank_sel = 0; reg_idx = 0; reg_we = 0; reg_wdata = 0;
    byte_addr = 0; byte_we = 0; byte_wdata = 0; bit_addr = 0; bit_we = 0;
    bit_wdata = 0; push = 0; pop = 0; stk_wdata = 0;
    @(negedge clk);
    do_reset();

    // R1: reset state
    #1 chk("R1 sp after reset", sp, 8'h07);
    wr_byte(7'h00, 8'h9C);
    wr_byte(7'h08, 8'h01);
    reg_idx = 3'd0; #1 chk("R1 bank 0 after reset", reg_rdata, 8'h9C);
    set_bank(2'd1);
    reg_idx = 3'd0; #1 chk("R2 bank 1 idx 0", reg_rdata, 8'h01);
    do_reset();
    reg_idx = 3'd0; #1 chk("R1 bank back to 0, memory kept", reg_rdata, 8'h9C);
    #1 chk("R1 sp after second reset", sp, 8'h07);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [7:0] a, d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        3'd0: wr_byte(a[6:0], d);
        3'd1: rd_byte("R3 R5 table byte read", a[6:0], e);
        3'd2: begin bit_addr = a[6:0]; bit_wdata = d[0]; bit_we = 1'b1; tick(); end
        3'd3: begin bit_addr = a[6:0]; #1 chk("R4 table bit read", {7'b0, bit_rdata}, e); end
        3'd4: begin set_bank(a[4:3]); reg_idx = a[2:0]; reg_wdata = d; reg_we = 1'b1; tick(); end
        default: begin set_bank(a[4:3]); reg_idx = a[2:0]; #1 chk("R2 table reg read", reg_rdata, e); end
      endcase
    end

    // R10: priority
    wr_byte(7'h40, 8'h00); wr_byte(7'h01, 8'h00); wr_byte(7'h21, 8'h00);
    wr_byte(7'h42, 8'h00);
    push = 1'b1; stk_wdata = 8'hAA;
    byte_addr = 7'h40; byte_wdata = 8'h77; byte_we = 1'b1; tick();
    #1 chk("R6 sp after push", sp, 8'h08);
    rd_byte("R10 byte loses to push", 7'h40, 8'h00);
    rd_byte("R6 pushed byte", 7'h08, 8'hAA);
    set_bank(2'd0);
    byte_addr = 7'h41; byte_wdata = 8'h12; byte_we = 1'b1;
    reg_idx = 3'd1; reg_wdata = 8'h34; reg_we = 1'b1; tick();
    rd_byte("R10 byte wins", 7'h41, 8'h12);
    rd_byte("R10 reg loses to byte", 7'h01, 8'h00);
    reg_idx = 3'd2; reg_wdata = 8'h56; reg_we = 1'b1;
    bit_addr = 7'h08; bit_wdata = 1'b1; bit_we = 1'b1; tick();
    rd_byte("R10 reg wins", 7'h02, 8'h56);
    rd_byte("R10 bit loses to reg", 7'h21, 8'h00);
    #1 chk("R7 read under sp", stk_rdata, 8'hAA);
    pop = 1'b1; byte_addr = 7'h42; byte_wdata = 8'h99; byte_we = 1'b1; tick();
    #1 chk("R7 sp after pop", sp, 8'h07);
    rd_byte("R10 byte loses to pop", 7'h42, 8'h00);

    // R6 R7 stack sequence
    stk_wdata = 8'hBB; push = 1'b1; tick();
    stk_wdata = 8'hCC; push = 1'b1; tick();
    #1 chk("R6 sp after two pushes", sp, 8'h09);
    #1 chk("R7 top of stack", stk_rdata, 8'hCC);
    pop = 1'b1; tick();
    #1 chk("R7 sp after pop", sp, 8'h08);
    #1 chk("R7 next top", stk_rdata, 8'hBB);
    // R11: push and pop together
    stk_wdata = 8'h5C; push = 1'b1; pop = 1'b1; tick();
    #1 chk("R11 sp push wins", sp, 8'h09);
    rd_byte("R11 data written", 7'h09, 8'h5C);

    // R8: wrap downward
    for (int k = 0; k < 10; k++) begin pop = 1'b1; tick(); end
    #1 chk("R8 sp wraps to FF", sp, 8'hFF);
    #1 chk("R9 high read is zero", stk_rdata, 8'h00);
    stk_wdata = 8'h66; push = 1'b1; tick();
    #1 chk("R8 sp wraps to 00", sp, 8'h00);
    rd_byte("R8 push at wrapped address", 7'h00, 8'h66);

    // R9: push above 7Fh
    for (int k = 0; k < 127; k++) begin stk_wdata = 8'h01; push = 1'b1; tick(); end
    #1 chk("R6 sp at 7F", sp, 8'h7F);
    rd_byte("R6 top byte", 7'h7F, 8'h01);
    stk_wdata = 8'hEE; push = 1'b1; tick();
    #1 chk("R9 sp moves to 80", sp, 8'h80);
    rd_byte("R9 write above 7F ignored", 7'h00, 8'h66);
    #1 chk("R9 read at 80 is zero", stk_rdata, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule